// File: doc/BRIEF.md
# Programmable Interrupt Request Controller

This block turns eight external interrupt request pins into one 4-bit interrupt level for a processor core. The pins are numbered IRQ15 down to IRQ8. On the `irq_pins` bus, bit 7 is IRQ15 and bit 0 is IRQ8. Every pin passes through a two-flop synchronizer, followed by one more history flop that is used for edge detection.

The block has two modes, chosen by a 2-bit mode register:

- **Disabled mode** (both mode bits zero). The upper four pins, IRQ15..IRQ12, carry a level that an external controller has already encoded. IRQ15 is the most significant bit. The block accepts a new value only after seeing it in two successive synchronized samples. Until then it keeps showing the last accepted value.
- **Enabled mode** (any mode bit set). Each line is qualified by its own programmed trigger type. A qualified request is recorded in a sense register. The output is the level of the highest-numbered pending line, where IRQn maps to level n.

Level 0000 means nothing is pending. Level 1111 is the non-maskable request. Software talks to the block through a single write port. A 2-bit selector picks one of three targets: the mode register, the packed trigger configuration, or a write-one-to-clear mask for edge-held sense bits.

Top module: `irq_level_ctrl`

## Requirements
- R1: After a synchronous reset, `level_out` is 0000, the block is in disabled mode, and every line is configured as active-high level.
- R2: In disabled mode, `level_out` shows pins 7..4 (pin 7 as MSB) once they have held a value long enough. The value appears after the fourth rising clock edge following the change. Pins 3..0 have no effect in this mode, and the code 1111 passes through like any other value.
- R3: In disabled mode, a change on pins 7..4 that lasts only one clock cycle never appears on `level_out`.
- R4: Writes with `wr_sel`=00 load the mode from `wr_data[1:0]`. Any nonzero mode enables the controller, and 00 disables it. Writes with `wr_sel`=11 change nothing.
- R5: Writes with `wr_sel`=01 load the trigger types. Line i uses `wr_data[2i+1:2i]`, with 00 = high level, 01 = low level, 10 = rising edge, 11 = falling edge.
- R6: A sense bit for an edge-triggered line stays set until a `wr_sel`=10 write has a 1 in `wr_data[i]`. Zero bits in the clear mask leave sense bits unchanged.
- R7: If an edge event and a clear of the same line land on the same clock edge, the sense bit ends up set.
- R8: In enabled mode, `level_out` is 8+i for the highest pending line i, and 0000 when no line is pending.
- R9: The sense bit of a level-triggered line follows its qualified input, and clear writes do not affect it.
- R10: In enabled mode, a pin change reaches `level_out` after the third rising clock edge. A mode change affects `level_out` after the edge that writes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pins | input | 8 | Request pins, bit 7 = IRQ15 … bit 0 = IRQ8 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 00 mode, 01 trigger types, 10 clear mask, 11 none |
| wr_data | input | 16 | Write data |
| level_out | output | 4 | Encoded interrupt level to the core |

## Verification
A rising edge on an edge-triggered line and a software clear of that same line can land on the same clock edge. The testbench provokes this by raising IRQ13 and timing a clear write with bit 5 set so that it lands exactly on the third edge after the pin change. That third edge is the one on which the synchronized rising edge is recorded. The check passes if the output stays at level 1101 afterwards, which shows that the new request survived the clear. A cycle-accurate reference model, compared on every clock, also confirms that no other line was affected by that write.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
    localparam int NLINES   = 8;
    localparam int LVL_W    = 4;
    localparam int BASE_LVL = (1 << LVL_W) - NLINES;
    localparam int CFG_W    = 2 * NLINES;
    localparam int SYNC_STG = 2;

    typedef enum logic [1:0] {
        TRIG_HIGH = 2'b00,
        TRIG_LOW  = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;

    typedef enum logic [1:0] {
        SEL_MODE  = 2'b00,
        SEL_TRIG  = 2'b01,
        SEL_CLEAR = 2'b10,
        SEL_NONE  = 2'b11
    } wsel_e;

    typedef struct packed {
        logic [NLINES-1:0] hit;
        logic [NLINES-1:0] edge_mode;
    } qual_t;

    // Highest set request wins; none pending gives zero.
    function automatic logic [LVL_W-1:0] pick_level(input logic [NLINES-1:0] req);
        logic [LVL_W-1:0] lv;
        lv = '0;
        for (int i = 0; i < NLINES; i++) begin
            if (req[i]) lv = LVL_W'(BASE_LVL + i);
        end
        return lv;
    endfunction
endpackage

// File: rtl/irqc_sync.sv
`timescale 1ns/1ps
module irqc_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    localparam int DEPTH = STAGES + 1;
    logic [W-1:0] pipe [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) pipe[k] <= '0;
        end else begin
            pipe[0] <= din;
            for (int k = 1; k < DEPTH; k++) pipe[k] <= pipe[k-1];
        end
    end

    assign cur  = pipe[STAGES-1];
    assign prev = pipe[STAGES];
endmodule

// File: rtl/irqc_qualify.sv
`timescale 1ns/1ps
module irqc_qualify
    import irqc_pkg::*;
(
    input  logic [NLINES-1:0] cur,
    input  logic [NLINES-1:0] prev,
    input  logic [CFG_W-1:0]  cfg,
    output qual_t             q
);
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        trig_e t;
        logic  h;
        assign t = trig_e'(cfg[2*i +: 2]);
        always_comb begin
            unique case (t)
                TRIG_HIGH: h = cur[i];
                TRIG_LOW:  h = ~cur[i];
                TRIG_RISE: h = cur[i] & ~prev[i];
                TRIG_FALL: h = ~cur[i] & prev[i];
                default:   h = 1'b0;
            endcase
        end
        assign q.hit[i]       = h;
        assign q.edge_mode[i] = (t == TRIG_RISE) || (t == TRIG_FALL);
    end
endmodule

// File: rtl/irqc_sense.sv
`timescale 1ns/1ps
module irqc_sense
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  qual_t             q,
    input  logic              clr_vld,
    input  logic [NLINES-1:0] clr_mask,
    output logic [NLINES-1:0] sense
);
    logic [NLINES-1:0] clr_eff;
    logic [NLINES-1:0] nxt;

    assign clr_eff = clr_vld ? clr_mask : '0;

    // New events take precedence over a clear on the same edge.
    for (genvar i = 0; i < NLINES; i++) begin : g_bit
        assign nxt[i] = q.edge_mode[i] ? ((sense[i] & ~clr_eff[i]) | q.hit[i])
                                       : q.hit[i];
    end

    always_ff @(posedge clk) begin
        if (rst) sense <= '0;
        else     sense <= nxt;
    end
endmodule

// File: rtl/irqc_lvl_filter.sv
`timescale 1ns/1ps
module irqc_lvl_filter
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] cur,
    input  logic [LVL_W-1:0] prev,
    output logic [LVL_W-1:0] lvl
);
    always_ff @(posedge clk) begin
        if (rst)              lvl <= '0;
        else if (cur == prev) lvl <= cur;
    end
endmodule

// File: rtl/irq_level_ctrl.sv
`timescale 1ns/1ps
module irq_level_ctrl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] irq_pins,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [CFG_W-1:0]  wr_data,
    output logic [LVL_W-1:0]  level_out
);
    logic [1:0]        mode_q;
    logic [CFG_W-1:0]  cfg_q;
    logic [NLINES-1:0] sync_cur;
    logic [NLINES-1:0] sync_prev;
    qual_t             qual;
    logic [NLINES-1:0] sense_q;
    logic [LVL_W-1:0]  filt_lvl;
    logic              clr_vld;
    logic [NLINES-1:0] clr_mask;
    logic              ctl_en;
    wsel_e             sel;

    assign sel      = wsel_e'(wr_sel);
    assign clr_vld  = wr_en && (sel == SEL_CLEAR);
    assign clr_mask = wr_data[NLINES-1:0];
    assign ctl_en   = |mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            cfg_q  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_MODE: mode_q <= wr_data[1:0];
                SEL_TRIG: cfg_q  <= wr_data;
                default:  ;
            endcase
        end
    end

    irqc_sync #(.W(NLINES), .STAGES(SYNC_STG)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (irq_pins),
        .cur  (sync_cur),
        .prev (sync_prev)
    );

    irqc_qualify u_qual (
        .cur  (sync_cur),
        .prev (sync_prev),
        .cfg  (cfg_q),
        .q    (qual)
    );

    irqc_sense u_sense (
        .clk      (clk),
        .rst      (rst),
        .q        (qual),
        .clr_vld  (clr_vld),
        .clr_mask (clr_mask),
        .sense    (sense_q)
    );

    irqc_lvl_filter u_filt (
        .clk  (clk),
        .rst  (rst),
        .cur  (sync_cur[NLINES-1 -: LVL_W]),
        .prev (sync_prev[NLINES-1 -: LVL_W]),
        .lvl  (filt_lvl)
    );

    assign level_out = ctl_en ? pick_level(sense_q) : filt_lvl;
endmodule

// File: rtl/irq_level_ctrl_chk.sv
`timescale 1ns/1ps
module irq_level_ctrl_chk
    import irqc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [1:0]        mode,
    input logic [NLINES-1:0] sync_cur,
    input logic [NLINES-1:0] sync_prev,
    input logic [NLINES-1:0] hit,
    input logic [NLINES-1:0] edge_mode,
    input logic              clr_vld,
    input logic [NLINES-1:0] clr_mask,
    input logic [NLINES-1:0] sense,
    input logic [LVL_W-1:0]  level_out
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (level_out == '0 && mode == 2'b00));

    assert_filter_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && $past(mode) == 2'b00 && level_out != $past(level_out))
        |-> $past(sync_cur[NLINES-1 -: LVL_W] == sync_prev[NLINES-1 -: LVL_W]));

    assert_prio_top_R8: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b00 && level_out != '0)
        |-> ((sense >> (level_out - LVL_W'(BASE_LVL))) == NLINES'(1)));

    assert_prio_none_R8: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b00 && level_out == '0) |-> sense == '0);

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        assert_edge_hold_R6: assert property (@(posedge clk) disable iff (rst)
            $past(edge_mode[i] && sense[i] && !(clr_vld && clr_mask[i])) |-> sense[i]);

        assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
            $past(edge_mode[i] && hit[i]) |-> sense[i]);
    end
endmodule

bind irq_level_ctrl irq_level_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode_q),
    .sync_cur  (sync_cur),
    .sync_prev (sync_prev),
    .hit       (qual.hit),
    .edge_mode (qual.edge_mode),
    .clr_vld   (clr_vld),
    .clr_mask  (clr_mask),
    .sense     (sense_q),
    .level_out (level_out)
);

// File: tb/irq_level_ctrl_tb.sv
`timescale 1ns/1ps
module irq_level_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  irq_pins;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [15:0] wr_data;
    logic [3:0]  level_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    irq_level_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .irq_pins  (irq_pins),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .level_out (level_out)
    );

    // Behavioural reference model
    logic [7:0]  hist[$];
    logic [1:0]  m_mode;
    logic [15:0] m_cfg;
    logic [7:0]  m_sense;
    logic [3:0]  m_filt;

    function automatic logic [3:0] model_out();
        logic [3:0] r;
        r = 4'd0;
        if (m_mode == 2'b00) return m_filt;
        for (int i = 0; i < 8; i++) if (m_sense[i]) r = 4'(8 + i);
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            hist.delete();
            m_mode = 0; m_cfg = 0; m_sense = 0; m_filt = 0;
        end else begin
            logic [7:0] p2, p3;
            hist.push_front(irq_pins);
            if (hist.size() > 4) void'(hist.pop_back());
            p2 = (hist.size() > 2) ? hist[2] : 8'h00;
            p3 = (hist.size() > 3) ? hist[3] : 8'h00;
            for (int i = 0; i < 8; i++) begin
                logic ev;
                logic clr;
                case (m_cfg[2*i +: 2])
                    2'b00: ev = p2[i];
                    2'b01: ev = !p2[i];
                    2'b10: ev = p2[i] && !p3[i];
                    default: ev = !p2[i] && p3[i];
                endcase
                clr = wr_en && wr_sel == 2'b10 && wr_data[i];
                if (m_cfg[2*i+1]) m_sense[i] = (m_sense[i] && !clr) || ev;
                else              m_sense[i] = ev;
            end
            if (p2[7:4] == p3[7:4]) m_filt = p2[7:4];
            if (wr_en && wr_sel == 2'b00) m_mode = wr_data[1:0];
            if (wr_en && wr_sel == 2'b01) m_cfg  = wr_data;
        end
    end

    task automatic chk(string req, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s level_out actual=%h expected=%h at %0t", req, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) chk((m_mode == 2'b00) ? "R2" : "R8", level_out, model_out());
    end

    task automatic cyc(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] s, logic [15:0] d);
        wr_en = 1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1; irq_pins = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
        cyc(3);
        rst = 0;
        cyc(1);
        chk("R1", level_out, 4'h0);

        // Disabled mode: encoded level on pins 7..4
        irq_pins = 8'hA5;
        cyc(3); chk("R2", level_out, 4'h0);
        cyc(1); chk("R2", level_out, 4'hA);
        // single-cycle glitch
        irq_pins = 8'hF0; cyc(1); irq_pins = 8'hA0;
        for (int k = 0; k < 8; k++) begin cyc(1); chk("R3", level_out, 4'hA); end
        irq_pins = 8'hF3; cyc(4); chk("R2", level_out, 4'hF);
        irq_pins = 8'h00; cyc(4); chk("R2", level_out, 4'h0);

        // Enable, default high-level triggers
        wr(2'b00, 16'h0001); chk("R4", level_out, 4'h0);
        irq_pins = 8'h05;
        cyc(2); chk("R10", level_out, 4'h0);
        cyc(1); chk("R10", level_out, 4'hA);
        irq_pins = 8'h00; cyc(3); chk("R9", level_out, 4'h0);

        // Line 0 low-level
        wr(2'b01, 16'h0001); cyc(2); chk("R5", level_out, 4'h8);
        wr(2'b10, 16'h00FF); chk("R9", level_out, 4'h8);

        // Line 5 rising edge, short pulse held
        wr(2'b01, 16'h0801);
        irq_pins = 8'h20; cyc(1); irq_pins = 8'h00;
        cyc(5); chk("R6", level_out, 4'hD);
        wr(2'b10, 16'h0010); cyc(1); chk("R6", level_out, 4'hD);
        wr(2'b10, 16'h0020); chk("R6", level_out, 4'h8);

        // Line 7 falling edge
        wr(2'b01, 16'hC801);
        irq_pins = 8'h80; cyc(4); chk("R5", level_out, 4'h8);
        irq_pins = 8'h00;
        cyc(2); chk("R5", level_out, 4'h8);
        cyc(1); chk("R5", level_out, 4'hF);
        irq_pins = 8'h01; wr(2'b10, 16'h00FF); cyc(2); chk("R6", level_out, 4'h0);

        // Event and clear of line 5 on the same edge
        irq_pins = 8'h21; cyc(2);
        wr(2'b10, 16'h0020);
        chk("R7", level_out, 4'hD);
        cyc(4); chk("R7", level_out, 4'hD);
        wr(2'b10, 16'h0020); chk("R6", level_out, 4'h0);

        // Priority with all lines high-level
        wr(2'b01, 16'h0000);
        irq_pins = 8'hFF; cyc(3); chk("R8", level_out, 4'hF);
        irq_pins = 8'h0F; cyc(3); chk("R8", level_out, 4'hB);
        irq_pins = 8'h00; cyc(3); chk("R8", level_out, 4'h0);

        // Mode encodings
        wr(2'b00, 16'h0002);
        irq_pins = 8'h40; cyc(3); chk("R4", level_out, 4'hE);
        cyc(2);
        wr(2'b00, 16'h0000); chk("R4", level_out, 4'h4);
        wr(2'b11, 16'hFFFF); cyc(2); chk("R4", level_out, 4'h4);
        irq_pins = 8'h4F; cyc(6); chk("R2", level_out, 4'h4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule